// File: doc/BRIEF.md
# Four-Channel Serial Backplane Demultiplexer

This block takes one high-speed serial backplane stream running at eight times the E1 rate (16.384 Mbit/s against 2.048 Mbit/s per channel) and splits it into four E1 channels. A single-cycle frame sync pulse marks bit position 0 of a 2048-period frame. In every pair of bit periods one bit is real data and the other is filler. The block throws the filler away, builds each channel's timeslot octets MSB first, and delivers each finished octet on that channel's own output stream, tagged with its timeslot number 0 to 31. A chip that needs eight channels places two instances, one per high-speed input.

A 2-bit ordering select picks one of three layouts. In bit-interleaved layout, successive data bits rotate through the channels. In the two octet-interleaved layouts, each channel's octet occupies one 16-period burst; the two layouts differ only in which bit of each pair carries the data. Octet N of all four channels always comes before octet N+1 of any channel. A global enable gates all delivery. The upstream source drives data on the rising clock edge, so every register in the block runs on the falling edge.

Each output lane is a valid/ready stream that cannot push back on the serial line. When a lane completes an octet, valid rises and octet and slot stay frozen until ready is seen high on a falling edge. If ready stays low until the lane's next octet completes (at least 15 periods later, normally 64), the newer octet replaces the held one. Ready has no effect on the serial side.

Top module: `bp_demux4`

## Requirements
- R1: A sampled sync pulse makes that sample frame position 0. Positions then advance by one per falling edge and wrap from 2047 to 0. Every data octet of the stream is delivered exactly once on its channel's lane.
- R2: With ordering select 00 or 01 (bit-interleaved), only even positions p carry data. The data belongs to channel (p/2) mod 4, bit index (p/8) mod 8, and timeslot p/64.
- R3: With ordering select 10 (octet-interleaved, data first), only even positions p carry data. The data belongs to channel (p/16) mod 4, bit index (p/2) mod 8, and timeslot p/64.
- R4: With ordering select 11 (octet-interleaved, data second), only odd positions p carry data. Channel, bit index and timeslot follow the same rule as in R3.
- R5: Filler positions have no effect on any delivered octet.
- R6: Bit index 0 of an octet is its MSB. The octet is presented, with its 5-bit timeslot number, after the falling edge that samples bit index 7. Lane i uses lane_octet[8i+7:8i] and lane_slot[5i+4:5i].
- R7: While mux_en is low, no lane completes an octet.
- R8: After reset, and until the first sync pulse is sampled, all lane_valid bits stay low and resync_seen is low.
- R9: A sync pulse sampled while locked, at any position other than the one after 2047, realigns the frame and sets resync_seen, which then stays set until reset. A sync pulse at the expected place does not set it.
- R10: An unaccepted octet keeps valid, octet and slot stable. Ready high on a falling edge with no new completion drops valid. A new completion on a lane replaces a held octet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 16.384 MHz bit clock, sampled on falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mux_en | input | 1 | Enables octet delivery |
| mode_sel | input | 2 | Ordering select: 0x bit-interleaved, 10 and 11 octet-interleaved |
| ser_in | input | 1 | High-speed serial data |
| fsync | input | 1 | One-cycle frame start pulse |
| lane_valid | output | 4 | Per-lane octet valid |
| lane_ready | input | 4 | Per-lane consumer ready |
| lane_octet | output | 32 | Per-lane octet, 8 bits per lane |
| lane_slot | output | 20 | Per-lane timeslot, 5 bits per lane |
| resync_seen | output | 1 | Sticky misplaced-sync flag |

## Verification
The hardest situations to reach from the ports are two. The first is a held octet being replaced because its consumer stalls longer than a lane's octet period. The second is a sync pulse arriving in the middle of a frame while octets are half built. The stimulus holds one lane's ready low for well over 64 periods, checks that the octet stays frozen and is then replaced, and lets the monitor skip the entries that were overwritten. It also fires a sync at position 700 and confirms that the flag is set and that every octet after the realignment is correct. The three orderings run under random filler and random ready, and windows with enable low and with no sync yet seen are watched for any stray valid.

// File: rtl/bpdmx_pkg.sv
package bpdmx_pkg;
  typedef enum logic [1:0] {
    ORD_BIT_A = 2'b00,
    ORD_BIT_B = 2'b01,
    ORD_OCT_EVEN = 2'b10,
    ORD_OCT_ODD = 2'b11
  } order_e;
endpackage

// File: rtl/bp_frame_tracker.sv
module bp_frame_tracker #(
  parameter int FRAME_LEN = 2048,
  parameter int POS_W = $clog2(FRAME_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fsync,
  output logic [POS_W-1:0] pos_cur,
  output logic             live,
  output logic             locked,
  output logic             resync_seen
);
  localparam logic [POS_W-1:0] LAST = POS_W'(FRAME_LEN - 1);

  logic [POS_W-1:0] pos_q;
  logic             at_end;
  logic             misplaced;

  assign at_end    = (pos_q == LAST);
  assign misplaced = fsync & locked & ~at_end;

  // position of the bit sampled on this falling edge
  always_comb begin
    if (fsync || at_end) pos_cur = '0;
    else                 pos_cur = pos_q + 1'b1;
  end

  assign live = locked | fsync;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q       <= LAST;
      locked      <= 1'b0;
      resync_seen <= 1'b0;
    end else begin
      pos_q <= pos_cur;
      if (fsync)     locked      <= 1'b1;
      if (misplaced) resync_seen <= 1'b1;
    end
  end

  AST_POS_ADVANCE: assert property (@(negedge clk) disable iff (!rst_n)
    locked && !fsync && !at_end |=> pos_q == $past(pos_q) + 1'b1); // R1
  AST_LOCK_NEEDS_SYNC: assert property (@(negedge clk) disable iff (!rst_n)
    !locked && !fsync |=> !locked); // R8
  AST_RESYNC_STICKY: assert property (@(negedge clk) disable iff (!rst_n)
    resync_seen |=> resync_seen); // R9
  AST_RESYNC_CAUSE: assert property (@(negedge clk) disable iff (!rst_n)
    !resync_seen && !(fsync && locked) |=> !resync_seen); // R9
endmodule

// File: rtl/bp_slot_decoder.sv
module bp_slot_decoder
  import bpdmx_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int SLOTS  = 32,
  parameter int OCT_W  = 8,
  parameter int CH_W   = $clog2(NUM_CH),
  parameter int BIT_W  = $clog2(OCT_W),
  parameter int SLOT_W = $clog2(SLOTS),
  parameter int POS_W  = 1 + CH_W + BIT_W + SLOT_W
) (
  input  logic [POS_W-1:0]  pos,
  input  logic [1:0]        mode_sel,
  input  logic              active,
  output logic [NUM_CH-1:0] sel,
  output logic              last_bit,
  output logic [SLOT_W-1:0] slot
);
  logic [CH_W-1:0]  ch;
  logic [BIT_W-1:0] bit_idx;
  logic             data_phase;
  logic             take;

  always_comb begin
    unique case (order_e'(mode_sel))
      ORD_OCT_EVEN, ORD_OCT_ODD: begin
        bit_idx    = pos[BIT_W:1];
        ch         = pos[BIT_W+CH_W:BIT_W+1];
        data_phase = (order_e'(mode_sel) == ORD_OCT_ODD);
      end
      default: begin
        ch         = pos[CH_W:1];
        bit_idx    = pos[CH_W+BIT_W:CH_W+1];
        data_phase = 1'b0;
      end
    endcase
  end

  assign slot     = pos[POS_W-1 -: SLOT_W];
  assign take     = active && (pos[0] == data_phase);
  assign last_bit = (bit_idx == BIT_W'(OCT_W - 1));

  always_comb begin
    sel = '0;
    if (take) sel[ch] = 1'b1;
  end
endmodule

// File: rtl/bp_lane_collect.sv
module bp_lane_collect #(
  parameter int OCT_W  = 8,
  parameter int SLOT_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              last_bit,
  input  logic              din,
  input  logic [SLOT_W-1:0] slot_in,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [OCT_W-1:0]  out_octet,
  output logic [SLOT_W-1:0] out_slot
);
  logic [OCT_W-2:0] sh_q;
  logic [OCT_W-1:0] full;
  logic             done;

  assign full = {sh_q, din};
  assign done = take & last_bit;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q      <= '0;
      out_valid <= 1'b0;
      out_octet <= '0;
      out_slot  <= '0;
    end else begin
      if (take) sh_q <= full[OCT_W-2:0];
      if (done) begin
        out_octet <= full;
        out_slot  <= slot_in;
        out_valid <= 1'b1;
      end else if (out_valid && out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  AST_HOLD_UNTIL_TAKEN: assert property (@(negedge clk) disable iff (!rst_n)
    out_valid && !out_ready && !done |=> out_valid && $stable(out_octet) && $stable(out_slot)); // R10
  AST_RELEASE_ON_TAKE: assert property (@(negedge clk) disable iff (!rst_n)
    out_valid && out_ready && !done |=> !out_valid); // R10
  AST_DONE_PRESENTS: assert property (@(negedge clk) disable iff (!rst_n)
    done |=> out_valid && out_slot == $past(slot_in)); // R6
endmodule

// File: rtl/bp_demux4.sv
module bp_demux4 #(
  parameter int NUM_CH = 4,
  parameter int SLOTS  = 32,
  parameter int OCT_W  = 8,
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     mux_en,
  input  logic [1:0]               mode_sel,
  input  logic                     ser_in,
  input  logic                     fsync,
  output logic [NUM_CH-1:0]        lane_valid,
  input  logic [NUM_CH-1:0]        lane_ready,
  output logic [NUM_CH*OCT_W-1:0]  lane_octet,
  output logic [NUM_CH*SLOT_W-1:0] lane_slot,
  output logic                     resync_seen
);
  localparam int CH_W      = $clog2(NUM_CH);
  localparam int BIT_W     = $clog2(OCT_W);
  localparam int FRAME_LEN = SLOTS * NUM_CH * OCT_W * 2;
  localparam int POS_W     = $clog2(FRAME_LEN);

  logic [POS_W-1:0]  pos_cur;
  logic              live;
  logic              locked;
  logic [NUM_CH-1:0] sel;
  logic              last_bit;
  logic [SLOT_W-1:0] slot;

  bp_frame_tracker #(
    .FRAME_LEN(FRAME_LEN),
    .POS_W(POS_W)
  ) u_track (
    .clk(clk),
    .rst_n(rst_n),
    .fsync(fsync),
    .pos_cur(pos_cur),
    .live(live),
    .locked(locked),
    .resync_seen(resync_seen)
  );

  bp_slot_decoder #(
    .NUM_CH(NUM_CH),
    .SLOTS(SLOTS),
    .OCT_W(OCT_W),
    .CH_W(CH_W),
    .BIT_W(BIT_W),
    .SLOT_W(SLOT_W),
    .POS_W(POS_W)
  ) u_dec (
    .pos(pos_cur),
    .mode_sel(mode_sel),
    .active(live & mux_en),
    .sel(sel),
    .last_bit(last_bit),
    .slot(slot)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_lane
    bp_lane_collect #(
      .OCT_W(OCT_W),
      .SLOT_W(SLOT_W)
    ) u_lane (
      .clk(clk),
      .rst_n(rst_n),
      .take(sel[g]),
      .last_bit(last_bit),
      .din(ser_in),
      .slot_in(slot),
      .out_valid(lane_valid[g]),
      .out_ready(lane_ready[g]),
      .out_octet(lane_octet[g*OCT_W +: OCT_W]),
      .out_slot(lane_slot[g*SLOT_W +: SLOT_W])
    );
  end

  AST_QUIET_BEFORE_LOCK: assert property (@(negedge clk) disable iff (!rst_n)
    !locked |-> lane_valid == '0); // R8
  AST_ONE_LANE_PER_BIT: assert property (@(negedge clk) disable iff (!rst_n)
    $onehot0(sel)); // R2
  AST_DISABLED_NO_NEW: assert property (@(negedge clk) disable iff (!rst_n)
    !mux_en && lane_valid == '0 |=> lane_valid == '0); // R7
endmodule

// File: tb/test_bp_demux4.sv
`timescale 1ns/1ps
module test_bp_demux4;
  logic        clk = 1'b0, rst_n = 1'b0, mux_en = 1'b0, ser_in = 1'b0, fsync = 1'b0;
  logic [1:0]  mode_sel = 2'b00;
  logic [3:0]  lane_ready = 4'b0, lane_valid;
  logic [31:0] lane_octet;
  logic [19:0] lane_slot;
  logic        resync_seen;

  always #2.5 clk = ~clk;

  bp_demux4 i_bp_demux4 (
    .clk(clk), .rst_n(rst_n), .mux_en(mux_en), .mode_sel(mode_sel),
    .ser_in(ser_in), .fsync(fsync), .lane_valid(lane_valid),
    .lane_ready(lane_ready), .lane_octet(lane_octet), .lane_slot(lane_slot),
    .resync_seen(resync_seen)
  );

  int checks = 0, errors = 0, cyc = 0;
  int pos = 0;
  bit bench_lock = 0, send_sync = 0, en_cur = 0, en_next = 0;
  logic [1:0] mode_cur = 2'b00, mode_next = 2'b00;
  logic [7:0] cur [4][32];
  logic [15:0] expq [4][$];
  bit quiet = 0, drop_ok = 0, hold0 = 0;
  int rdy_pct = 75;
  string quiet_tag = "R8";

  function automatic void decode(input logic [1:0] m, input int p,
                                 output bit v, output int ch, output int b, output int s);
    s = p / 64;
    if (m[1]) begin
      v  = ((p % 2) == ((m == 2'b11) ? 1 : 0));
      ch = (p / 16) % 4;
      b  = (p / 2) % 8;
    end else begin
      v  = ((p % 2) == 0);
      ch = (p / 2) % 4;
      b  = (p / 8) % 8;
    end
  endfunction

  function automatic string mode_tag(input logic [1:0] m);
    if (m == 2'b10) return "R3";
    if (m == 2'b11) return "R4";
    return "R2";
  endfunction

  task automatic step(input bit force_sync);
    bit ds, v;
    int ch, b, s;
    @(posedge clk);
    ds = force_sync || (send_sync && pos == 0);
    if (ds) pos = 0;
    if (pos == 0) begin
      en_cur = en_next;
      mode_cur = mode_next;
      mux_en <= en_next;
      mode_sel <= mode_next;
      for (int c = 0; c < 4; c++)
        for (int t = 0; t < 32; t++) cur[c][t] = 8'($urandom);
    end
    if (ds) bench_lock = 1;
    decode(mode_cur, pos, v, ch, b, s);
    ser_in <= v ? cur[ch][s][7-b] : 1'($urandom);
    fsync <= ds;
    if (v && b == 7 && bench_lock && en_cur)
      expq[ch].push_back({mode_cur, 1'b0, 5'(s), cur[ch][s]});
    pos = (pos + 1) % 2048;
  endtask

  task automatic run(input int n);
    for (int k = 0; k < n; k++) step(0);
  endtask

  task automatic to_boundary();
    while (pos != 0) step(0);
  endtask

  task automatic accept(input int i);
    logic [7:0] got;
    logic [4:0] gs;
    logic [15:0] e;
    int dropped;
    got = lane_octet[i*8 +: 8];
    gs = lane_slot[i*5 +: 5];
    dropped = 0;
    while (expq[i].size() > 0 && expq[i][0][12:8] != gs) begin
      void'(expq[i].pop_front());
      dropped++;
    end
    checks++;
    if (expq[i].size() == 0) begin
      errors++;
      $display("FAIL R1 lane %0d unexpected octet slot %0d got %02h expected none", i, gs, got);
    end else begin
      e = expq[i].pop_front();
      if (dropped > 0 && !drop_ok) begin
        errors++;
        $display("FAIL R1 R10 lane %0d slot %0d skipped %0d octets, expected 0", i, gs, dropped);
      end else if (e[7:0] != got) begin
        errors++;
        $display("FAIL %s R5 R6 lane %0d slot %0d octet got %02h expected %02h",
                 mode_tag(e[15:14]), i, gs, got, e[7:0]);
      end
    end
  endtask

  always @(posedge clk) begin
    for (int i = 0; i < 4; i++)
      lane_ready[i] <= (hold0 && i == 0) ? 1'b0 : (($urandom % 100) < rdy_pct);
  end

  always @(posedge clk) begin
    #1;
    for (int i = 0; i < 4; i++) begin
      if (lane_valid[i]) begin
        if (quiet) begin
          checks++;
          errors++;
          $display("FAIL %s lane %0d valid got 1 expected 0", quiet_tag, i);
        end
        if (lane_ready[i]) accept(i);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int got, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got %0d expected %0d", tag, got, exp);
    end
  endtask

  initial begin
    logic [7:0] h_oct;
    logic [4:0] h_slot;
    process::self().srandom(32'h5eed_0042);
    en_next = 1;
    mode_next = 2'b00;
    #20;
    chk(lane_valid == 4'b0, "R8 reset lane_valid", int'(lane_valid), 0);
    chk(resync_seen == 1'b0, "R8 reset resync_seen", int'(resync_seen), 0);
    @(posedge clk);
    rst_n <= 1'b1;

    // no sync yet: enable high, random data, nothing may come out
    quiet_tag = "R8";
    quiet = 1;
    run(300);
    quiet = 0;
    chk(lane_valid == 4'b0, "R8 pre-lock lane_valid", int'(lane_valid), 0);

    // bit-interleaved frames
    send_sync = 1;
    step(1);
    run(2 * 2048 - 1);
    to_boundary();
    // octet-interleaved, data in even phase
    mode_next = 2'b10;
    run(2 * 2048);
    to_boundary();
    // octet-interleaved, data in odd phase
    mode_next = 2'b11;
    run(2 * 2048);
    to_boundary();
    chk(resync_seen == 1'b0, "R9 regular syncs leave flag clear", int'(resync_seen), 0);

    // enable low for a whole frame
    en_next = 0;
    step(0);
    run(100);
    quiet_tag = "R7";
    quiet = 1;
    to_boundary();
    quiet = 0;
    chk(lane_valid == 4'b0, "R7 disabled frame lane_valid", int'(lane_valid), 0);

    // back-pressure on lane 0
    en_next = 1;
    mode_next = 2'b00;
    run(200);
    hold0 = 1;
    step(0);
    while (!lane_valid[0]) step(0);
    h_oct = lane_octet[7:0];
    h_slot = lane_slot[4:0];
    run(20);
    chk(lane_valid[0] == 1'b1, "R10 held valid", int'(lane_valid[0]), 1);
    chk(lane_octet[7:0] == h_oct, "R10 held octet", int'(lane_octet[7:0]), int'(h_oct));
    chk(lane_slot[4:0] == h_slot, "R10 held slot", int'(lane_slot[4:0]), int'(h_slot));
    run(150);
    chk(lane_slot[4:0] != h_slot, "R10 replaced slot differs", int'(lane_slot[4:0]), int'(h_slot) + 1);
    drop_ok = 1;
    hold0 = 0;
    run(100);
    drop_ok = 0;

    // misplaced sync
    to_boundary();
    mode_next = 2'b10;
    run(700);
    step(1);
    step(0);
    chk(resync_seen == 1'b1, "R9 misplaced sync sets flag", int'(resync_seen), 1);
    run(2 * 2048);
    chk(resync_seen == 1'b1, "R9 flag stays set", int'(resync_seen), 1);

    // drain everything
    to_boundary();
    en_next = 0;
    rdy_pct = 100;
    run(200);
    for (int i = 0; i < 4; i++)
      chk(expq[i].size() == 0, "R1 all octets delivered", expq[i].size(), 0);
    chk(lane_valid == 4'b0, "R10 drained lane_valid", int'(lane_valid), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule